// File: doc/BRIEF.md
# Strap Latch Power-up Sequencer

This block takes a clock generator from the moment its supply is good to the point where its clock outputs may run. After the supply is good it waits for an active-low power-good strobe from the processor voltage regulator. The strobe is synchronised and must be seen low on two clocks in a row before it counts. A qualified strobe starts a settling delay counted in timer ticks. When that delay ends, the two frequency-select straps are captured once. A second wait, for the oscillator to stabilise, then runs before the output enable is raised.

The strobe is a one-shot. Once it has been taken, further strobe edges and strap changes have no effect until the supply drops. The one exception is a strap FS_B held at its middle level when the strobe qualifies. In that case the sequencer enters a test-clock mode that only a supply drop can clear. In test mode the captured code stays zero and the FS_A strap keeps steering a live choice between tri-stated outputs and reference-divided outputs.

Both delays are parameters counted in ticks of an external timebase. The defaults, 250 and 1800 ticks, assume a 1 µs tick. The captured code is laid out as the low two bits of the first control register: bit 0 holds FS_A and bit 1 holds FS_B.

Top module: `strap_pwrup_seq`

## Requirements
- R1: With reset asserted and in the first cycle after reset, out_en, test_mode, test_hiz and freq_code are all zero.
- R2: pwrgd_n passes through a two-flop synchroniser. It counts only when the synchronised value is low on two consecutive clocks, so a low pulse of one clock never starts the sequence.
- R3: The straps are captured after the qualified strobe plus DLY_TICKS tick pulses. The captured value is the strap value at that moment, so strap changes during the delay are taken in.
- R4: out_en rises only after STAB_TICKS further tick pulses have followed the capture, and never earlier.
- R5: freq_code bit 0 is the captured fs_a. freq_code bit 1 is 1 only when fs_b was high. fs_b codes are 2'b00 low, 2'b01 mid, and 2'b10 or 2'b11 high.
- R6: Once the strobe has qualified outside test mode, later changes on pwrgd_n, fs_a and fs_b leave freq_code and out_en unchanged.
- R7: If fs_b equals 2'b01 at the clock edge where the strobe qualifies, test_mode becomes 1 and stays 1 while supply_ok is high. freq_code stays 2'b00.
- R8: test_hiz equals fs_a without delay while test_mode is 1: 1 selects tri-stated outputs and 0 selects reference-divided outputs. test_hiz is 0 outside test mode.
- R9: supply_ok low at any clock edge returns the block to off on that edge, clearing out_en, test_mode and freq_code. A new qualified strobe is then needed before the sequence runs again.
- R10: Once raised, out_en stays high until supply_ok drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication, already synchronous to clk |
| pwrgd_n | input | 1 | Active-low power-good strobe, asynchronous |
| fs_a | input | 1 | Binary frequency-select strap |
| fs_b | input | 2 | Three-level frequency-select strap, encoded |
| tick | input | 1 | One-clock timebase pulse |
| freq_code | output | 2 | Captured straps {fs_b high, fs_a} |
| test_mode | output | 1 | Sticky test-clock mode flag |
| test_hiz | output | 1 | Test-mode choice: 1 selects Hi-Z, 0 selects REF/N |
| out_en | output | 1 | Clock output enable |

## Verification
The assertions assume three things about the inputs. First, supply_ok and tick are already synchronous to clk. Second, tick is a single-clock pulse. Third, pwrgd_n holds its level across the reset period, so the synchroniser's view of history is valid from the first edge after reset. The stimulus changes every input only on the falling clock edge and generates tick from a free-running divide-by-three. It holds pwrgd_n high throughout reset. The delays are shortened to a few ticks so that every path, including test mode and supply drops in the middle of a sequence, completes quickly.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

  typedef enum logic [2:0] {
    SQ_OFF    = 3'd0,
    SQ_WAIT   = 3'd1,
    SQ_DELAY  = 3'd2,
    SQ_SETTLE = 3'd3,
    SQ_RUN    = 3'd4
  } seq_state_t;

  localparam logic [1:0] FSB_LOW = 2'b00;
  localparam logic [1:0] FSB_MID = 2'b01;

  function automatic logic fsb_is_mid(input logic [1:0] code);
    return code == FSB_MID;
  endfunction

  function automatic logic fsb_is_high(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic [1:0] strap_code(input logic fsa, input logic [1:0] fsb);
    return {fsb_is_high(fsb), fsa};
  endfunction

endpackage

// File: rtl/pwrgd_sync.sv
module pwrgd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic strobe_low
);
  logic meta_q, sync_q, held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      held_q <= 1'b1;
    end else begin
      meta_q <= raw_n;
      sync_q <= meta_q;
      held_q <= sync_q;
    end
  end

  assign strobe_low = ~sync_q & ~held_q;

  // R2: qualification needs two consecutive low samples of the raw strobe
  p_two_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> ($past(raw_n, 2) == 1'b0 && $past(raw_n, 3) == 1'b0));

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (clr)                     cnt <= '0;
    else if (tick && cnt != CNT_TOP)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/strap_pwrup_seq.sv
module strap_pwrup_seq
  import strap_seq_pkg::*;
#(
  parameter int DLY_TICKS  = 250,
  parameter int STAB_TICKS = 1800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       pwrgd_n,
  input  logic       fs_a,
  input  logic [1:0] fs_b,
  input  logic       tick,
  output logic [1:0] freq_code,
  output logic       test_mode,
  output logic       test_hiz,
  output logic       out_en
);
  localparam int MAX_TICKS = (DLY_TICKS > STAB_TICKS) ? DLY_TICKS : STAB_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 2);
  localparam logic [CNT_W-1:0] DLY_L  = CNT_W'(DLY_TICKS);
  localparam logic [CNT_W-1:0] STAB_L = CNT_W'(STAB_TICKS);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic             strobe_low, phase_change, dly_done, stab_done;
  logic             take_strobe, capture;
  logic             test_q;
  logic [1:0]       freq_q;

  pwrgd_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_n      (pwrgd_n),
    .strobe_low (strobe_low)
  );

  tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (phase_change),
    .tick  (tick),
    .cnt   (cnt)
  );

  assign dly_done     = (cnt == DLY_L);
  assign stab_done    = (cnt == STAB_L);
  assign phase_change = (state_d != state_q);
  assign take_strobe  = supply_ok && state_q == SQ_WAIT && strobe_low;
  assign capture      = supply_ok && state_q == SQ_DELAY && dly_done;

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = SQ_OFF;
    end else begin
      case (state_q)
        SQ_OFF:    state_d = SQ_WAIT;
        SQ_WAIT:   if (strobe_low) state_d = SQ_DELAY;
        SQ_DELAY:  if (dly_done)   state_d = SQ_SETTLE;
        SQ_SETTLE: if (stab_done)  state_d = SQ_RUN;
        SQ_RUN:    state_d = SQ_RUN;
        default:   state_d = SQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_OFF;
      test_q  <= 1'b0;
      freq_q  <= 2'b00;
    end else begin
      state_q <= state_d;
      if (!supply_ok || state_q == SQ_OFF) begin
        test_q <= 1'b0;
        freq_q <= 2'b00;
      end else begin
        if (take_strobe && fsb_is_mid(fs_b)) test_q <= 1'b1;
        if (capture && !test_q)              freq_q <= strap_code(fs_a, fs_b);
      end
    end
  end

  assign freq_code = freq_q;
  assign test_mode = test_q;
  assign test_hiz  = test_q & fs_a;
  assign out_en    = (state_q == SQ_RUN);

  // R9: a supply drop clears everything on the next edge
  p_supply_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!out_en && !test_mode && freq_code == 2'b00));

  // R7: test mode is sticky while the supply holds
  p_test_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && supply_ok) |=> test_mode);

  // R7: no strap code is captured in test mode
  p_test_nocode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> freq_code == 2'b00);

  // R6: once captured, the code holds while the supply holds
  p_freq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SQ_SETTLE || state_q == SQ_RUN) && supply_ok) |=> $stable(freq_code));

  // R4: enable rises only at the end of the stabilisation wait
  p_en_after_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> ($past(state_q) == SQ_SETTLE && $past(stab_done)));

  // R10: enable stays high while the supply holds
  p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && supply_ok) |=> out_en);

endmodule

// File: tb/strap_pwrup_seq_test.sv
module strap_pwrup_seq_test;
  localparam int DLY  = 5;
  localparam int STAB = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic       pwrgd_n = 1'b1;
  logic       fs_a = 1'b0;
  logic [1:0] fs_b = 2'b00;
  logic       tick = 1'b0;
  logic [1:0] freq_code;
  logic       test_mode, test_hiz, out_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  strap_pwrup_seq #(.DLY_TICKS(DLY), .STAB_TICKS(STAB)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwrgd_n(pwrgd_n),
    .fs_a(fs_a), .fs_b(fs_b), .tick(tick), .freq_code(freq_code),
    .test_mode(test_mode), .test_hiz(test_hiz), .out_en(out_en)
  );

  always #2 clk = ~clk;

  initial begin : tick_gen
    int tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc == 2);
      tc = (tc == 2) ? 0 : tc + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 off, 1 wait, 2 delay, 3 settle, 4 run
  int m_phase = 0, m_cnt = 0;
  bit m_test = 0;
  bit [1:0] m_freq = 0;
  bit h1 = 1, h2 = 1, h3 = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_test = 0; m_freq = 0; h1 = 1; h2 = 1; h3 = 1;
    end else begin
      int nxt;
      bit qual;
      qual = (h2 == 0 && h3 == 0);
      nxt = m_phase;
      if (!supply_ok) begin
        nxt = 0; m_test = 0; m_freq = 0;
      end else begin
        if (m_phase == 0) begin nxt = 1; m_test = 0; m_freq = 0; end
        else if (m_phase == 1 && qual) begin
          nxt = 2;
          if (fs_b == 2'b01) m_test = 1;
        end else if (m_phase == 2 && m_cnt == DLY) begin
          nxt = 3;
          if (!m_test) m_freq = {fs_b[1], fs_a};
        end else if (m_phase == 3 && m_cnt == STAB) nxt = 4;
      end
      if (nxt != m_phase) m_cnt = 0;
      else if (tick) m_cnt++;
      m_phase = nxt;
      h3 = h2; h2 = h1; h1 = pwrgd_n;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R10 out_en vs model", out_en, (m_phase == 4));
      chk("R5 freq_code vs model", freq_code, m_freq);
      chk("R7 test_mode vs model", test_mode, m_test);
      chk("R8 test_hiz vs model", test_hiz, m_test & fs_a);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_en(output int n);
    n = 0;
    while (!out_en && n < 1000) begin
      @(negedge clk); #1; n++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int n;
    cyc(3); #1;
    chk("R1 reset out_en", out_en, 0);
    chk("R1 reset test_mode", test_mode, 0);
    chk("R1 reset freq_code", freq_code, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 first cycle out_en", out_en, 0);
    supply_ok = 1'b1;
    cyc(4);
    // R2: one-clock glitch must not start anything
    pwrgd_n = 1'b0; @(negedge clk); pwrgd_n = 1'b1;
    cyc(3 * (DLY + STAB) + 20); #1;
    chk("R2 glitch ignored out_en", out_en, 0);
    // R3: straps changed during delay are captured
    @(negedge clk); fs_a = 1'b0; fs_b = 2'b00; pwrgd_n = 1'b0;
    cyc(6); fs_a = 1'b1; fs_b = 2'b10;
    wait_en(n);
    chk("R3 late strap captured", freq_code, 3);
    chk("R4 enable reached", out_en, 1);
    chk("R4 enable not too early", (n >= 3 * STAB - 3) ? 1 : 0, 1);
    // R6: later changes ignored
    @(negedge clk); pwrgd_n = 1'b1; fs_a = 1'b0; fs_b = 2'b01;
    cyc(5); pwrgd_n = 1'b0; cyc(40); #1;
    chk("R6 code held", freq_code, 3);
    chk("R6 enable held", out_en, 1);
    chk("R6 no test mode", test_mode, 0);
    // R9: supply drop
    @(negedge clk); supply_ok = 1'b0; pwrgd_n = 1'b1;
    @(negedge clk); #1;
    chk("R9 drop out_en", out_en, 0);
    chk("R9 drop code", freq_code, 0);
    @(negedge clk); supply_ok = 1'b1;
    cyc(3 * (DLY + STAB) + 20); #1;
    chk("R9 needs new strobe", out_en, 0);
    // R5: fs_b=11 is high, fs_a=0
    @(negedge clk); fs_a = 1'b0; fs_b = 2'b11; pwrgd_n = 1'b0;
    wait_en(n);
    chk("R5 code 11 high", freq_code, 2);
    @(negedge clk); supply_ok = 1'b0; pwrgd_n = 1'b1;
    @(negedge clk); supply_ok = 1'b1; cyc(4);
    // R5: low straps
    fs_a = 1'b1; fs_b = 2'b00; pwrgd_n = 1'b0;
    wait_en(n);
    chk("R5 code low fsb", freq_code, 1);
    @(negedge clk); supply_ok = 1'b0; pwrgd_n = 1'b1;
    @(negedge clk); supply_ok = 1'b1; cyc(4);
    // R7/R8: test mode
    fs_a = 1'b0; fs_b = 2'b01; pwrgd_n = 1'b0;
    cyc(6); #1;
    chk("R7 test entered", test_mode, 1);
    chk("R8 refn selected", test_hiz, 0);
    fs_a = 1'b1; #1;
    chk("R8 hiz selected live", test_hiz, 1);
    @(negedge clk); fs_b = 2'b00; pwrgd_n = 1'b1;
    wait_en(n);
    chk("R7 test sticky", test_mode, 1);
    chk("R7 no code in test", freq_code, 0);
    chk("R10 enable in test", out_en, 1);
    fs_a = 1'b0; #1;
    chk("R8 refn again", test_hiz, 0);
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk); #1;
    chk("R9 test cleared", test_mode, 0);
    chk("R9 hiz cleared", test_hiz, 0);
    cyc(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule